// File: doc/BRIEF.md
# Cyclic Sense and Timed Wake-Up Controller

This block supervises a chip while it sits in a low-power mode. Once low-power mode is entered, a period timer counts microsecond ticks and starts a new cycle each time the programmed period runs out. At the start of every cycle the block can switch on a high-side output for a short pulse. A sample strobe fires a fixed 10 ticks before that pulse ends, and at that moment the wake-up inputs are captured. A captured pattern that differs from the previous capture raises a wake-up event. Separately from sensing, the same timer can raise a wake-up event at the end of every period.

A three-bit control register, written from outside, enables each function: cyclic pulsing, forced wake-up and input sensing. The register is cleared by the block reset and by a mode-transition reset pulse. The period comes from an eight-entry table of non-uniform lengths selected by a three-bit code. A divisor parameter scales every period so that short runs are practical. The pulse width is a parameter counted in ticks.

Top module: `csw_cyclic_wake`

## Requirements
- R1: With the period divisor D, the cycle length in ticks for select codes 0 to 7 is 4600/D, 9250/D, 18500/D, 37000/D, 74000/D, 95500/D, 191000/D and 388000/D, with integer division.
- R2: In low-power mode with cyclic enable (control bit 0) set, `hs_drive` is high for the first PULSE_TICKS ticks of each cycle and low for the rest of the cycle, counting ticks rather than clocks.
- R3: `hs_drive` stays low outside low-power mode, and it stays low throughout low-power mode while cyclic enable is clear.
- R4: With cyclic enable and sense enable (control bit 2) both set, `sample_stb` is high for one clock right after the tick that leaves 10 ticks of the pulse remaining. Sampling occurs only in this case.
- R5: The first sample taken after entering low-power mode, or after sensing is re-enabled, only stores the reference pattern and never raises an event.
- R6: A sample that differs in any bit from the previous sample raises `wake_evt` together with the sense flag, `wake_cause` bit 0, in the same clock as the strobe.
- R7: With forced wake-up enabled (control bit 1) in low-power mode, `wake_evt` rises together with the forced flag, `wake_cause` bit 1, in the clock after the final tick of every period. The first such event comes one full period after entry.
- R8: `wake_cause` is zero whenever `wake_evt` is low. When a forced event and a sensed event share a clock, they produce a single event with both flags set.
- R9: When low-power mode ends, `hs_drive` drops in the same clock. The cycle count and any pending sample are discarded, so re-entry starts a fresh cycle whose first sample is again only a reference.
- R10: A change of `period_sel` during low-power mode takes effect from the next cycle start. The period at entry is the one selected before entry.
- R11: `ctrl_q` reads back the last written control value. It is cleared by `rst` and by `mode_rst`, and a clear wins over a write in the same clock.
- R12: Every wake-up event lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-clock strobe per microsecond tick |
| lp_mode | input | 1 | High while the chip is in sleep or stop |
| period_sel | input | 3 | Cycle period select code |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 3 | Control write data: bit 2 sense, bit 1 forced wake, bit 0 cyclic |
| mode_rst | input | 1 | Mode-transition reset pulse, clears the control register |
| wake_in | input | NUM_WAKE | Wake-up input levels |
| ctrl_q | output | 3 | Current control register value |
| hs_drive | output | 1 | High-side switch drive |
| sample_stb | output | 1 | One-clock sampling strobe |
| wake_evt | output | 1 | One-clock wake-up event |
| wake_cause | output | 2 | Event source flags: bit 1 forced, bit 0 sensed |

## Verification
The assertions assume that `tick_us` is a single-clock strobe and that the pulse is longer than the 10-tick lead and shorter than the shortest scaled period. They also assume that the control bits do not change in the middle of a low-power stretch when strobe and event timing is compared. The stimulus keeps to these limits. It writes the configuration only while low-power mode is off. It uses a divisor of 100 with a 20-tick pulse. It draws tick density, select codes, enables and rare wake-input changes from a seeded generator. A cycle model in the bench predicts every output on every clock.

// File: rtl/csw_pkg.sv
package csw_pkg;

    // Control register layout: bit 2 sense, bit 1 forced wake, bit 0 cyclic.
    typedef struct packed {
        logic sense_en;
        logic fwu_en;
        logic cyc_en;
    } csw_ctrl_t;

    // Event source flags: bit 1 forced, bit 0 sensed.
    typedef struct packed {
        logic forced;
        logic sensed;
    } csw_cause_t;

    localparam int unsigned CSW_SAMPLE_LEAD = 10;
    localparam int unsigned CSW_SEL_W       = 3;

    // Nominal cycle length in microseconds for each select code.
    function automatic int unsigned csw_period_us(input logic [CSW_SEL_W-1:0] sel);
        int unsigned us;
        case (sel)
            3'd0:    us = 4600;
            3'd1:    us = 9250;
            3'd2:    us = 18500;
            3'd3:    us = 37000;
            3'd4:    us = 74000;
            3'd5:    us = 95500;
            3'd6:    us = 191000;
            default: us = 388000;
        endcase
        return us;
    endfunction

    function automatic int unsigned csw_period_ticks(input logic [CSW_SEL_W-1:0] sel,
                                                     input int unsigned div);
        return csw_period_us(sel) / div;
    endfunction

endpackage

// File: rtl/csw_ctrl_reg.sv
module csw_ctrl_reg
    import csw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mode_rst,
    input  logic      cfg_we,
    input  csw_ctrl_t cfg_wdata,
    output csw_ctrl_t ctrl
);

    always_ff @(posedge clk) begin
        if (rst || mode_rst) begin
            ctrl <= '0;
        end else if (cfg_we) begin
            ctrl <= cfg_wdata;
        end
    end

    // A mode-transition reset always leaves the register cleared.
    assert_mode_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $past(mode_rst) |-> (ctrl == '0));

endmodule

// File: rtl/csw_period_timer.sv
module csw_period_timer
    import csw_pkg::*;
#(
    parameter int unsigned PERIOD_DIV = 1,
    parameter int unsigned CNT_W      = 19
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 lp_mode,
    input  logic [CSW_SEL_W-1:0] period_sel,
    output logic [CNT_W-1:0]     cnt,
    output logic                 cycle_end
);

    logic [CNT_W-1:0] per_lat;
    logic [CNT_W-1:0] sel_ticks;

    assign sel_ticks = CNT_W'(csw_period_ticks(period_sel, PERIOD_DIV));
    assign cycle_end = lp_mode && tick && (cnt == per_lat - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            per_lat <= CNT_W'(csw_period_ticks(3'd0, PERIOD_DIV));
        end else if (!lp_mode) begin
            cnt     <= '0;
            per_lat <= sel_ticks;
        end else if (tick) begin
            if (cnt == per_lat - CNT_W'(1)) begin
                cnt     <= '0;
                per_lat <= sel_ticks;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (rst)
        cnt < per_lat);

    assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> (cnt == '0));

    // The latched period only moves at a cycle start or outside low power.
    assert_period_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(lp_mode) && !$past(cycle_end)) |-> $stable(per_lat));

endmodule

// File: rtl/csw_pulse_gen.sv
module csw_pulse_gen
    import csw_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 200,
    parameter int unsigned CNT_W       = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             lp_mode,
    input  csw_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] cnt,
    output logic             hs_drive,
    output logic             samp_now,
    output logic             sample_stb
);

    localparam logic [CNT_W-1:0] SAMP_AT = CNT_W'(PULSE_TICKS - CSW_SAMPLE_LEAD - 1);
    localparam logic [CNT_W-1:0] PULSE_W = CNT_W'(PULSE_TICKS);

    assign hs_drive = lp_mode && ctrl.cyc_en && (cnt < PULSE_W);
    assign samp_now = lp_mode && tick && ctrl.cyc_en && ctrl.sense_en && (cnt == SAMP_AT);

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_stb <= 1'b0;
        end else begin
            sample_stb <= samp_now;
        end
    end

    assert_strobe_in_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> $past(hs_drive));

    assert_no_strobe_unsensed_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(ctrl.sense_en) |-> !sample_stb);

endmodule

// File: rtl/csw_wake_detect.sv
module csw_wake_detect
    import csw_pkg::*;
#(
    parameter int unsigned NUM_WAKE = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lp_mode,
    input  csw_ctrl_t           ctrl,
    input  logic                samp_now,
    input  logic                cycle_end,
    input  logic [NUM_WAKE-1:0] wake_in,
    output logic                wake_evt,
    output csw_cause_t          wake_cause
);

    logic [NUM_WAKE-1:0] ref_q;
    logic                ref_ok;
    logic [NUM_WAKE-1:0] chg;
    logic                sense_hit;
    logic                forced_hit;

    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_cmp
        assign chg[g] = wake_in[g] ^ ref_q[g];
    end

    assign sense_hit  = samp_now && ref_ok && (|chg);
    assign forced_hit = ctrl.fwu_en && cycle_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q      <= '0;
            ref_ok     <= 1'b0;
            wake_evt   <= 1'b0;
            wake_cause <= '0;
        end else begin
            if (!lp_mode || !ctrl.sense_en || !ctrl.cyc_en) begin
                ref_ok <= 1'b0;
            end else if (samp_now) begin
                ref_q  <= wake_in;
                ref_ok <= 1'b1;
            end
            wake_evt          <= sense_hit || forced_hit;
            wake_cause.forced <= forced_hit;
            wake_cause.sensed <= sense_hit;
        end
    end

    assert_cause_matches_evt_R8: assert property (@(posedge clk) disable iff (rst)
        wake_evt == (wake_cause != '0));

    assert_sensed_at_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        wake_cause.sensed |-> $past(samp_now));

    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> !wake_evt);

endmodule

// File: rtl/csw_cyclic_wake.sv
module csw_cyclic_wake
    import csw_pkg::*;
#(
    parameter int unsigned PERIOD_DIV  = 1,
    parameter int unsigned PULSE_TICKS = 200,
    parameter int unsigned NUM_WAKE    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_us,
    input  logic                lp_mode,
    input  logic [2:0]          period_sel,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_wdata,
    input  logic                mode_rst,
    input  logic [NUM_WAKE-1:0] wake_in,
    output logic [2:0]          ctrl_q,
    output logic                hs_drive,
    output logic                sample_stb,
    output logic                wake_evt,
    output logic [1:0]          wake_cause
);

    localparam int unsigned MAX_TICKS = csw_period_ticks(3'd7, PERIOD_DIV);
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    csw_ctrl_t        ctrl;
    csw_cause_t       cause;
    logic [CNT_W-1:0] cnt;
    logic             cycle_end;
    logic             samp_now;

    csw_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode_rst  (mode_rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (csw_ctrl_t'(cfg_wdata)),
        .ctrl      (ctrl)
    );

    csw_period_timer #(
        .PERIOD_DIV (PERIOD_DIV),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_us),
        .lp_mode    (lp_mode),
        .period_sel (period_sel),
        .cnt        (cnt),
        .cycle_end  (cycle_end)
    );

    csw_pulse_gen #(
        .PULSE_TICKS (PULSE_TICKS),
        .CNT_W       (CNT_W)
    ) u_pulse (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_us),
        .lp_mode    (lp_mode),
        .ctrl       (ctrl),
        .cnt        (cnt),
        .hs_drive   (hs_drive),
        .samp_now   (samp_now),
        .sample_stb (sample_stb)
    );

    csw_wake_detect #(
        .NUM_WAKE (NUM_WAKE)
    ) u_wake (
        .clk        (clk),
        .rst        (rst),
        .lp_mode    (lp_mode),
        .ctrl       (ctrl),
        .samp_now   (samp_now),
        .cycle_end  (cycle_end),
        .wake_in    (wake_in),
        .wake_evt   (wake_evt),
        .wake_cause (cause)
    );

    assign ctrl_q     = ctrl;
    assign wake_cause = cause;

    initial begin
        assert_pulse_fits_R2: assert (PULSE_TICKS > CSW_SAMPLE_LEAD &&
                                      PULSE_TICKS < csw_period_ticks(3'd0, PERIOD_DIV));
    end

    // No event is ever produced from a clock spent outside low power.
    assert_evt_needs_lp_R9: assert property (@(posedge clk) disable iff (rst)
        wake_evt |-> $past(lp_mode));

endmodule

// File: tb/csw_cyclic_wake_tb_top.sv
module csw_cyclic_wake_tb_top;

    localparam int unsigned DIV   = 100;
    localparam int unsigned PULSE = 20;
    localparam int unsigned NW    = 4;
    localparam int unsigned LEAD  = 10;
    localparam int unsigned MAXN  = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_us = 1'b0;
    logic          lp_mode = 1'b0;
    logic [2:0]    period_sel = 3'd0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_wdata = 3'd0;
    logic          mode_rst = 1'b0;
    logic [NW-1:0] wake_in = '0;
    logic [2:0]    ctrl_q;
    logic          hs_drive;
    logic          sample_stb;
    logic          wake_evt;
    logic [1:0]    wake_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Stimulus schedule for one low-power stretch
    logic          tk [MAXN];
    logic [NW-1:0] wv [MAXN];
    logic [2:0]    sv [MAXN];
    bit c_cyc, c_fwu, c_sen;

    always #10 clk = ~clk;

    csw_cyclic_wake #(
        .PERIOD_DIV  (DIV),
        .PULSE_TICKS (PULSE),
        .NUM_WAKE    (NW)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick_us    (tick_us),
        .lp_mode    (lp_mode),
        .period_sel (period_sel),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .mode_rst   (mode_rst),
        .wake_in    (wake_in),
        .ctrl_q     (ctrl_q),
        .hs_drive   (hs_drive),
        .sample_stb (sample_stb),
        .wake_evt   (wake_evt),
        .wake_cause (wake_cause)
    );

    // R1 period table, scaled by the divisor
    function automatic int tab(input logic [2:0] s);
        case (s)
            3'd0: return 4600 / DIV;
            3'd1: return 9250 / DIV;
            3'd2: return 18500 / DIV;
            3'd3: return 37000 / DIV;
            3'd4: return 74000 / DIV;
            3'd5: return 95500 / DIV;
            3'd6: return 191000 / DIV;
            default: return 388000 / DIV;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic [2:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        c_cyc = v[0]; c_fwu = v[1]; c_sen = v[2];
    endtask

    // Drive one low-power stretch of n clocks and compare each clock
    // against the cycle model built from the requirements.
    task automatic run_lp(input int n, input string tag);
        int  mcnt = 0;
        int  mper;
        bit  mref_ok = 0;
        logic [NW-1:0] mref = '0;
        bit  p_stb = 0, p_evt = 0;
        logic [1:0] p_cause = 2'b00;
        bit  e_hs;
        bit  nstb, nsh, nfw;
        @(negedge clk);
        lp_mode = 1'b0; period_sel = sv[0]; tick_us = 1'b0;
        @(negedge clk);
        mper = tab(sv[0]); // R10: period at entry is the one selected before entry
        lp_mode = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick_us = tk[i]; wake_in = wv[i]; period_sel = sv[i];
            #1;
            e_hs = c_cyc && (mcnt < PULSE);
            check(hs_drive == e_hs, {tag, " R2 R3 hs_drive"}, hs_drive, e_hs);
            check(sample_stb == p_stb, {tag, " R4 sample_stb"}, sample_stb, p_stb);
            check(wake_evt == p_evt && wake_cause == p_cause,
                  {tag, " R5 R6 R7 R8 R12 wake_evt/cause"},
                  {wake_evt, wake_cause}, {p_evt, p_cause});
            nstb = tk[i] && c_cyc && c_sen && (mcnt == PULSE - LEAD - 1);
            nsh  = nstb && mref_ok && (wv[i] != mref);
            nfw  = tk[i] && c_fwu && (mcnt == mper - 1);
            if (nstb) begin mref = wv[i]; mref_ok = 1; end
            if (tk[i]) begin
                if (mcnt == mper - 1) begin mcnt = 0; mper = tab(sv[i]); end
                else mcnt++;
            end
            p_stb = nstb; p_evt = nsh || nfw; p_cause = {nfw, nsh};
            @(negedge clk);
        end
        lp_mode = 1'b0; tick_us = 1'b0;
        #1;
        // R9: drive drops in the same clock that low power ends
        check(hs_drive == 1'b0, {tag, " R9 hs off at exit"}, hs_drive, 0);
    endtask

    task automatic fill(input int n, input int tick_mode, input logic [2:0] s,
                        input logic [NW-1:0] w0, input int chg_at);
        for (int i = 0; i < n; i++) begin
            tk[i] = (tick_mode == 0) ? 1'b1 :
                    (tick_mode == 1) ? logic'(i % 2 == 0) : logic'($urandom % 4 != 0);
            sv[i] = s;
            if (i == 0) wv[i] = w0;
            else if (chg_at < 0) wv[i] = ($urandom % 40 == 0) ? NW'($urandom) : wv[i-1];
            else wv[i] = (i == chg_at) ? ~wv[i-1] : wv[i-1];
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        check(ctrl_q == 3'd0, "R11 ctrl after rst", ctrl_q, 0);
        check(hs_drive == 0 && sample_stb == 0 && wake_evt == 0 && wake_cause == 0,
              "R3 outputs idle after rst", {hs_drive, sample_stb, wake_evt}, 0);

        // R11 write, mode reset, and clear winning over a write
        write_cfg(3'b101);
        #1; check(ctrl_q == 3'b101, "R11 readback", ctrl_q, 5);
        @(negedge clk); mode_rst = 1'b1; @(negedge clk); mode_rst = 1'b0; #1;
        check(ctrl_q == 3'd0, "R11 mode_rst clears", ctrl_q, 0);
        @(negedge clk); mode_rst = 1'b1; cfg_we = 1'b1; cfg_wdata = 3'b111;
        @(negedge clk); mode_rst = 1'b0; cfg_we = 1'b0; #1;
        check(ctrl_q == 3'd0, "R11 clear beats write", ctrl_q, 0);
        write_cfg(3'b011);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; #1;
        check(ctrl_q == 3'd0, "R11 rst clears", ctrl_q, 0);
        c_cyc = 0; c_fwu = 0; c_sen = 0;

        // R3: enables clear, nothing happens in low power
        fill(120, 0, 3'd0, 4'h3, 30);
        run_lp(120, "idle");

        // R1 R2: cyclic pulses only, no strobe with sense clear (R4)
        write_cfg(3'b001);
        fill(150, 0, 3'd0, 4'h5, -1);
        run_lp(150, "cyclic");

        // R5 R6 R12: sensing with a single input change between strobes
        write_cfg(3'b101);
        fill(200, 0, 3'd1, 4'h9, 60);
        run_lp(200, "sense");

        // R9: exit before the first strobe, then re-enter with a changed pattern
        fill(5, 0, 3'd0, 4'h1, -1);
        run_lp(5, "early exit");
        fill(120, 0, 3'd0, 4'hE, -1);
        run_lp(120, "re-entry");

        // R2: ticks every other clock stretch the pulse in clocks
        write_cfg(3'b111);
        fill(250, 1, 3'd0, 4'h2, 70);
        run_lp(250, "half ticks");

        // R10: select change mid-cycle applies from the next cycle
        write_cfg(3'b011);
        fill(260, 0, 3'd0, 4'h0, -1);
        for (int i = 20; i < 260; i++) sv[i] = 3'd2;
        run_lp(260, "sel change");

        // R1 R7: forced wake-up at the end of each table entry's period
        write_cfg(3'b010);
        for (int s = 0; s < 8; s++) begin
            fill(tab(3'(s)) + 3, 0, 3'(s), 4'h0, -1);
            run_lp(tab(3'(s)) + 3, "table");
        end

        // Random mix of enables, select codes, tick density and inputs
        for (int r = 0; r < 8; r++) begin
            logic [2:0] s;
            int n;
            write_cfg(3'($urandom));
            s = 3'($urandom % 3);
            n = 3 * tab(s) + 20 + int'($urandom % 30);
            if (n >= MAXN) n = MAXN - 1;
            fill(n, 2 * int'($urandom % 2), s, NW'($urandom), -1);
            run_lp(n, "random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule